// File: doc/BRIEF.md
# Round-Robin Iterative Crossbar Matcher

This block computes, for an N-by-N input-queued crossbar, which inputs may send to which outputs in the next cell slot. Each input presents one request bit per output, which is normally the "not empty" flag of its per-output queue. A start strobe hands the whole request matrix to the matcher. It then runs repeated rounds of grant and accept arbitration, one per clock, until it stops. It returns a conflict-free match matrix together with a single-cycle done strobe.

Every output keeps a round-robin grant pointer and every input keeps a round-robin accept pointer. A pointer advances only when the grant it produced is actually accepted, and only in the first iteration of a round. As a result, under heavy load the output pointers spread apart and the match settles into a rotating, collision-free pattern. Later iterations fill in ports that the first iteration left idle, without disturbing the fairness state.

Top module: `islip_sched`

## Requirements
- R1: Request and match matrices use bit index i*N+j for "input i to output j". A match matrix never holds more than one bit in any row or any column.
- R2: A match bit is set only where the request matrix captured at start had the same bit set.
- R3: In each iteration, every free output grants the free requesting input found first when scanning upward from its grant pointer and wrapping past N-1 to 0.
- R4: Every input that received grants accepts the granting output found first when scanning upward from its accept pointer, with the same wrap.
- R5: In the first iteration of a round only, an output whose grant was accepted by input i sets its grant pointer to (i+1) mod N. An input that accepted output j sets its accept pointer to (j+1) mod N. All other pointers keep their value.
- R6: A port matched in an earlier iteration of a round keeps that match and takes no part in later iterations.
- R7: Iterations run one per clock, up to ITERS per round. The round ends after the iteration that adds no new match, or after iteration ITERS, whichever comes first. done rises n clocks after the edge that samples start, where n is the number of iterations executed.
- R8: done is high for exactly one clock. match_o holds its value from the end of one round until the next accepted start.
- R9: start_i is ignored while a round is running, and req_i is sampled only on the edge that accepts start.
- R10: A synchronous reset clears the match, the done strobe and every pointer to zero and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a round when the block is idle |
| req_i | input | N*N | Request matrix, bit i*N+j = input i wants output j |
| match_o | output | N*N | Match matrix, same bit layout |
| done_o | output | 1 | One-cycle strobe: match_o is final |

## Verification
On every cycle, the bound checker verifies that the match is conflict-free, that it stays within the captured requests, that matches only accumulate during a round, that the iteration count stays within bounds, that done is a single pulse, and that the match is held while idle. The bench's scenarios are the only evidence for the round-robin choices and for how pointers evolve from round to round, which appear as the rotating match pattern over repeated full-load rounds. The same holds for early termination, for the iteration cap of a one-iteration instance, for a start ignored mid-round, and for pointers returning to zero after reset.

// File: rtl/islip_pkg.sv
package islip_pkg;

   typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_e;

   // position of the set bit in a one-hot word (zero when none set)
   function automatic int unsigned oh_index(input logic [63:0] oh);
      int unsigned r;
      r = 0;
      for (int k = 0; k < 64; k++) begin
         if (oh[k]) r = k;
      end
      return r;
   endfunction

   // successor of idx in a ring of n positions
   function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned n);
      return (idx + 1 >= n) ? 0 : idx + 1;
   endfunction

endpackage

// File: rtl/islip_rr_pick.sv
// Programmable priority encoder: one-hot pick of the first set request
// at or above ptr_i, wrapping to the bottom when none lies above.
module islip_rr_pick #(
   parameter int N    = 4,
   parameter int PW   = 2,
   parameter bit SCAN = 1'b0
) (
   input  logic [N-1:0]  req_i,
   input  logic [PW-1:0] ptr_i,
   output logic [N-1:0]  pick_o
);
   localparam logic [N-1:0] ONE = N'(1);

   if (SCAN == 1'b0) begin : g_mask
      // two fixed-priority encoders: masked upper half, then whole vector
      logic [N-1:0] hi_mask, upper, upper_low, all_low;
      assign hi_mask   = {N{1'b1}} << ptr_i;
      assign upper     = req_i & hi_mask;
      assign upper_low = upper & (~upper + ONE);
      assign all_low   = req_i & (~req_i + ONE);
      assign pick_o    = (|upper) ? upper_low : all_low;
   end else begin : g_scan
      // rotating linear scan, smaller but deeper
      always_comb begin
         logic hit;
         int   idx;
         pick_o = '0;
         hit    = 1'b0;
         for (int k = 0; k < N; k++) begin
            idx = int'(ptr_i) + k;
            if (idx >= N) idx = idx - N;
            if (!hit && req_i[idx[PW-1:0]]) begin
               pick_o[idx[PW-1:0]] = 1'b1;
               hit = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/islip_grant_stage.sv
// One arbiter per output: chooses among free inputs requesting it.
module islip_grant_stage #(
   parameter int N    = 4,
   parameter int PW   = 2,
   parameter bit SCAN = 1'b0
) (
   input  logic [N*N-1:0]  req_i,
   input  logic [N-1:0]    in_free_i,
   input  logic [N-1:0]    out_free_i,
   input  logic [N*PW-1:0] ptr_i,
   output logic [N*N-1:0]  gnt_o
);
   for (genvar j = 0; j < N; j++) begin : g_out
      logic [N-1:0] col;
      logic [N-1:0] pick;
      for (genvar i = 0; i < N; i++) begin : g_in
         assign col[i] = req_i[i*N+j] & in_free_i[i] & out_free_i[j];
         assign gnt_o[i*N+j] = pick[i];
      end
      islip_rr_pick #(.N(N), .PW(PW), .SCAN(SCAN)) u_pick (
         .req_i  (col),
         .ptr_i  (ptr_i[j*PW +: PW]),
         .pick_o (pick)
      );
   end
endmodule

// File: rtl/islip_accept_stage.sv
// One arbiter per input: chooses among outputs that granted it.
module islip_accept_stage #(
   parameter int N    = 4,
   parameter int PW   = 2,
   parameter bit SCAN = 1'b0
) (
   input  logic [N*N-1:0]  gnt_i,
   input  logic [N*PW-1:0] ptr_i,
   output logic [N*N-1:0]  acc_o
);
   for (genvar i = 0; i < N; i++) begin : g_in
      islip_rr_pick #(.N(N), .PW(PW), .SCAN(SCAN)) u_pick (
         .req_i  (gnt_i[i*N +: N]),
         .ptr_i  (ptr_i[i*PW +: PW]),
         .pick_o (acc_o[i*N +: N])
      );
   end
endmodule

// File: rtl/islip_sched.sv
module islip_sched #(
   parameter int N         = 4,
   parameter int ITERS     = N,
   parameter bit SCAN_PICK = 1'b0
) (
   input  logic           clk_i,
   input  logic           rst_i,
   input  logic           start_i,
   input  logic [N*N-1:0] req_i,
   output logic [N*N-1:0] match_o,
   output logic           done_o
);
   import islip_pkg::*;

   localparam int NN = N * N;
   localparam int PW = $clog2(N);
   localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1;
   localparam logic [IW-1:0] LAST_IT = IW'(ITERS - 1);

   if (N < 2 || N > 64) begin : g_bad_n
      $error("islip_sched: N must lie in 2..64");
   end
   if (ITERS < 1 || ITERS > N) begin : g_bad_iters
      $error("islip_sched: ITERS must lie in 1..N");
   end

   phase_e          state_q;
   logic            busy_q;
   logic [IW-1:0]   iter_q;
   logic [NN-1:0]   req_q;
   logic [NN-1:0]   match_q;
   logic            done_q;
   logic [NN-1:0]   gnt, acc;
   logic [N-1:0]    in_free, out_free;
   logic [N*PW-1:0] gptr_flat, aptr_flat;
   logic [PW-1:0]   gptr_q [N];
   logic [PW-1:0]   aptr_q [N];
   logic            first_iter;

   assign busy_q     = (state_q == PH_RUN);
   assign first_iter = busy_q && (iter_q == '0);

   // free-port vectors from the accumulated match
   for (genvar i = 0; i < N; i++) begin : g_inf
      assign in_free[i] = ~|match_q[i*N +: N];
   end
   for (genvar j = 0; j < N; j++) begin : g_outf
      logic [N-1:0] col;
      for (genvar i = 0; i < N; i++) begin : g_b
         assign col[i] = match_q[i*N+j];
      end
      assign out_free[j] = ~|col;
   end

   islip_grant_stage #(.N(N), .PW(PW), .SCAN(SCAN_PICK)) u_grant (
      .req_i      (req_q),
      .in_free_i  (in_free),
      .out_free_i (out_free),
      .ptr_i      (gptr_flat),
      .gnt_o      (gnt)
   );

   islip_accept_stage #(.N(N), .PW(PW), .SCAN(SCAN_PICK)) u_accept (
      .gnt_i (gnt),
      .ptr_i (aptr_flat),
      .acc_o (acc)
   );

   // round control
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= PH_IDLE;
         iter_q  <= '0;
         req_q   <= '0;
         match_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            PH_IDLE: begin
               if (start_i) begin
                  req_q   <= req_i;
                  match_q <= '0;
                  iter_q  <= '0;
                  state_q <= PH_RUN;
               end
            end
            default: begin
               match_q <= match_q | acc;
               iter_q  <= iter_q + 1'b1;
               if (!(|acc) || iter_q == LAST_IT) begin
                  state_q <= PH_IDLE;
                  done_q  <= 1'b1;
               end
            end
         endcase
      end
   end

   // grant pointers: one per output, moved past the accepting input
   for (genvar j = 0; j < N; j++) begin : g_gptr
      logic [N-1:0] col;
      for (genvar i = 0; i < N; i++) begin : g_b
         assign col[i] = acc[i*N+j];
      end
      always_ff @(posedge clk_i) begin
         if (rst_i)
            gptr_q[j] <= '0;
         else if (first_iter && (|col))
            gptr_q[j] <= PW'(wrap_inc(oh_index(64'(col)), N));
      end
      assign gptr_flat[j*PW +: PW] = gptr_q[j];
   end

   // accept pointers: one per input, moved past the accepted output
   for (genvar i = 0; i < N; i++) begin : g_aptr
      logic [N-1:0] row;
      assign row = acc[i*N +: N];
      always_ff @(posedge clk_i) begin
         if (rst_i)
            aptr_q[i] <= '0;
         else if (first_iter && (|row))
            aptr_q[i] <= PW'(wrap_inc(oh_index(64'(row)), N));
      end
      assign aptr_flat[i*PW +: PW] = aptr_q[i];
   end

   assign match_o = match_q;
   assign done_o  = done_q;

endmodule

// File: rtl/islip_sched_chk.sv
module islip_sched_chk #(
   parameter int N     = 4,
   parameter int ITERS = N,
   parameter int IW    = 2
) (
   input logic           clk_i,
   input logic           rst_i,
   input logic           start_i,
   input logic [N*N-1:0] req_i,
   input logic [N*N-1:0] match_o,
   input logic           done_o,
   input logic           busy_i,
   input logic [IW-1:0]  iter_i
);
   logic [N*N-1:0] cap_req;

   always_ff @(posedge clk_i) begin
      if (rst_i)                    cap_req <= '0;
      else if (!busy_i && start_i)  cap_req <= req_i;
   end

   for (genvar i = 0; i < N; i++) begin : g_row
      p_row_onehot_r1: assert property (@(posedge clk_i) disable iff (rst_i)
         $onehot0(match_o[i*N +: N]));
   end

   for (genvar j = 0; j < N; j++) begin : g_col
      logic [N-1:0] col;
      for (genvar i = 0; i < N; i++) begin : g_b
         assign col[i] = match_o[i*N+j];
      end
      p_col_onehot_r1: assert property (@(posedge clk_i) disable iff (rst_i)
         $onehot0(col));
   end

   p_within_req_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (match_o & ~cap_req) == '0);

   p_keep_matched_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      busy_i |=> ((match_o & $past(match_o)) == $past(match_o)));

   p_iter_bound_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      busy_i |-> (int'(iter_i) < ITERS));

   p_done_after_run_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> $past(busy_i));

   p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !done_o);

   p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      (!busy_i && !start_i) |=> $stable(match_o));

   p_clear_r10: assert property (@(posedge clk_i)
      rst_i |=> (match_o == '0 && !done_o && !busy_i));

endmodule

bind islip_sched islip_sched_chk #(.N(N), .ITERS(ITERS), .IW(IW)) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .start_i (start_i),
   .req_i   (req_i),
   .match_o (match_o),
   .done_o  (done_o),
   .busy_i  (busy_q),
   .iter_i  (iter_q)
);

// File: tb/sim_islip_sched.sv
`timescale 1ns/1ps
module sim_islip_sched;
   localparam int N = 4;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start0 = 1'b0, start1 = 1'b0;
   logic [15:0]   req = '0;
   logic [15:0]   match0, match1;
   logic          done0, done1;
   int            checks = 0;
   int            errors = 0;

   always #2.5 clk = ~clk;

   islip_sched #(.N(N), .ITERS(N)) u0 (
      .clk_i(clk), .rst_i(rst), .start_i(start0), .req_i(req),
      .match_o(match0), .done_o(done0));

   islip_sched #(.N(N), .ITERS(1)) u1 (
      .clk_i(clk), .rst_i(rst), .start_i(start1), .req_i(req),
      .match_o(match1), .done_o(done1));

   // back-to-back full-load rounds then a sparse one, from reset pointers
   localparam logic [15:0] T_REQ [5] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h8013};
   localparam logic [15:0] T_EXP [5] = '{16'h8421, 16'h8412, 16'h8124, 16'h1248, 16'h8001};
   localparam int          T_CYC [5] = '{4, 4, 3, 2, 2};

   task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chkint(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run(input bit sel, input logic [15:0] r, input int poke,
                      output logic [15:0] m, output int cyc);
      @(negedge clk);
      req = r;
      if (sel) start1 = 1'b1; else start0 = 1'b1;
      @(negedge clk);
      start0 = 1'b0; start1 = 1'b0;
      cyc = 0;
      while (!(sel ? done1 : done0) && cyc < 40) begin
         if (cyc == poke) begin
            req = '0;
            start0 = 1'b1;
         end
         @(negedge clk);
         start0 = 1'b0;
         cyc++;
      end
      m = sel ? match1 : match0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] m;
      int          cyc;

      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk16("R10 reset match u0", match0, 16'h0000);
      chkint("R10 reset done u0", int'(done0), 0);
      chk16("R10 reset match u1", match1, 16'h0000);

      // table walk: R1 R2 R3 R4 R5 R6 via match, R7 via latency, R8 after done
      for (int t = 0; t < 5; t++) begin
         run(1'b0, T_REQ[t], -1, m, cyc);
         chk16($sformatf("R1 R2 R3 R4 R5 R6 round %0d match", t), m, T_EXP[t]);
         chkint($sformatf("R7 round %0d iterations", t), cyc, T_CYC[t]);
         @(negedge clk);
         chkint($sformatf("R8 round %0d done width", t), int'(done0), 0);
         chk16($sformatf("R8 round %0d match held", t), match0, T_EXP[t]);
      end

      // R7 empty request ends after one iteration with no match
      run(1'b0, 16'h0000, -1, m, cyc);
      chk16("R7 empty match", m, 16'h0000);
      chkint("R7 empty iterations", cyc, 1);

      // R7 iteration cap on the single-iteration instance (R5 between rounds)
      run(1'b1, 16'hFFFF, -1, m, cyc);
      chk16("R7 cap1 round0 match", m, 16'h0001);
      chkint("R7 cap1 round0 iterations", cyc, 1);
      run(1'b1, 16'hFFFF, -1, m, cyc);
      chk16("R5 R7 cap1 round1 match", m, 16'h0012);
      chkint("R7 cap1 round1 iterations", cyc, 1);

      // R10 pointers return to zero: full load repeats the first pattern
      do_reset();
      run(1'b0, 16'hFFFF, -1, m, cyc);
      chk16("R10 pointer reset match", m, 16'h8421);
      chkint("R10 pointer reset iterations", cyc, 4);

      // R9 start and new req mid-round are ignored
      do_reset();
      run(1'b0, 16'hFFFF, 2, m, cyc);
      chk16("R9 mid-round start match", m, 16'h8421);
      chkint("R9 mid-round start iterations", cyc, 4);
      begin
         int extra;
         extra = 0;
         for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (done0) extra++;
         end
         chkint("R9 no second round", extra, 0);
      end
      chk16("R9 match kept", match0, 16'h8421);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule